// File: doc/BRIEF.md
# Multi-Input Wake-Up Interrupt Unit

The unit watches groups of eight external wake-up pins and turns activity on them into per-pin pending flags and one interrupt line per group. Each pin can be set to react to a high level, a low level, a rising edge, a falling edge or any edge. Every pin has its own input enable, which gates detection, and its own interrupt enable, which gates the pending flag onto the group interrupt.

Software reaches all configuration, pending and enable state through a small synchronous register port. The address carries the group number in its upper bits and a register index in the low three bits. Pending flags are cleared by writing ones to a write-one-to-clear register. The pins are asynchronous to the unit's clock and pass through a synchronizer before any detection happens. Any interrupt controller that consumes the group interrupt lines sits outside the unit.

Top module: `wake_irq_unit`

## Requirements
- R1: After reset every configuration register, every input enable, every interrupt enable and every pending flag reads 0, and every group interrupt is low.
- R2: A pin passes through SYNC_STAGES flops (default 2) before detection. With the default, a rising edge driven between two clock edges makes the pending flag and the group interrupt visible after the third following rising clock edge, and not after the second.
- R3: Register index 0 is the mode register: 1 selects level detection and 0 selects edge detection. Index 1 is the polarity register: 0 selects high level or rising edge, and 1 selects low level or falling edge. In edge mode without any-edge, a transition in the opposite direction sets nothing.
- R4: In level mode the pending flag is set on every cycle that the active level is present. A clear issued while the level persists leaves the flag set.
- R5: Register index 2 is the any-edge register. In edge mode a 1 there makes both rising and falling transitions set the pending flag, whatever the polarity bit holds.
- R6: Register index 6 is the pending-clear register. Writing 1 to a bit clears that pending flag, and writing 0 to a bit leaves it unchanged. Reads of index 6 return 0.
- R7: When a detected event and a clear of the same bit fall in the same cycle, the flag ends up set.
- R8: Register index 3 holds the input enables. A pending flag is only set while its input enable is 1. Enabling a level-mode pin whose active level is already present sets its pending flag.
- R9: Register index 4 holds the interrupt enables. A group interrupt is high exactly when some pin of the group has both its pending flag and its interrupt enable at 1. Changing an interrupt enable alters neither the pending flags nor the other configuration registers.
- R10: Address bits [ADDR_W-1:3] select the group and bits [2:0] select the register. Index 5 reads the pending flags, and writes to it are ignored. A read request returns its data with rd_valid one cycle later.
- R11: The groups are independent: pin activity in one group sets only that group's pending flags and raises only that group's interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_pins | input | NUM_GROUPS*8 | Asynchronous wake-up pins; pin 8*g+k is lane k of group g |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read request |
| addr | input | ADDR_W | {group, register index} |
| wdata | input | 8 | Write data, one bit per lane |
| rdata | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | High one cycle after rd_en |
| irq | output | NUM_GROUPS | Per-group interrupt lines |

## Verification
The bench counts synchronizer latency to the exact edge, so a design with one flop too few or too many raises the interrupt a cycle early or late. It clears a level-mode flag while the level is still held, and this also covers a clear that coincides with an event. A design that let the clear win would show a flag at 0 where it must read 1. It drives opposite-direction edges, with and without any-edge, to catch a polarity or override decode that is inverted. It enables a level pin whose active level is already present, checks that the interrupt enable gates only the output, and confirms that a write of zeros to the clear register and traffic in another group leave the pending flags alone.

// File: rtl/wiu_pkg.sv
package wiu_pkg;
   localparam int LANES = 8;
   localparam int REG_IDX_W = 3;

   typedef enum logic [REG_IDX_W-1:0] {
      REG_MODE  = 3'd0,
      REG_POL   = 3'd1,
      REG_ANY   = 3'd2,
      REG_INEN  = 3'd3,
      REG_IRQEN = 3'd4,
      REG_PEND  = 3'd5,
      REG_CLR   = 3'd6
   } wiu_reg_e;
endpackage

// File: rtl/wiu_sync.sv
module wiu_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/wiu_group.sv
module wiu_group
   import wiu_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LANES-1:0]     pins,
   input  logic                 we,
   input  logic [REG_IDX_W-1:0] reg_sel,
   input  logic [LANES-1:0]     wdata,
   output logic [LANES-1:0]     rdata,
   output logic                 irq
);
   logic [LANES-1:0] mode_q, pol_q, any_q, inen_q, irqen_q, pend_q;
   logic [LANES-1:0] cur, prev_q, rise, fall, lvl_hit, edge_hit;
   logic [LANES-1:0] event_v, set_v, clr_v;

   wiu_sync #(.WIDTH(LANES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pins), .q(cur)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         pol_q   <= '0;
         any_q   <= '0;
         inen_q  <= '0;
         irqen_q <= '0;
      end else if (we) begin
         case (reg_sel)
            REG_MODE:  mode_q  <= wdata;
            REG_POL:   pol_q   <= wdata;
            REG_ANY:   any_q   <= wdata;
            REG_INEN:  inen_q  <= wdata;
            REG_IRQEN: irqen_q <= wdata;
            default:   ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= '0;
      else        prev_q <= cur;

   always_comb begin
      rise     = cur & ~prev_q;
      fall     = ~cur & prev_q;
      lvl_hit  = cur ^ pol_q;
      edge_hit = (any_q & (rise | fall))
               | (~any_q & ~pol_q & rise)
               | (~any_q & pol_q & fall);
      event_v  = (mode_q & lvl_hit) | (~mode_q & edge_hit);
      set_v    = event_v & inen_q;
      clr_v    = (we && reg_sel == REG_CLR) ? wdata : '0;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_v) | set_v;

   assign irq = |(pend_q & irqen_q);

   always_comb begin
      case (reg_sel)
         REG_MODE:  rdata = mode_q;
         REG_POL:   rdata = pol_q;
         REG_ANY:   rdata = any_q;
         REG_INEN:  rdata = inen_q;
         REG_IRQEN: rdata = irqen_q;
         REG_PEND:  rdata = pend_q;
         default:   rdata = '0;
      endcase
   end

   // R8: a flag only rises on a lane that was input-enabled
   assert_no_set_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(inen_q)) == '0));

   // R7: a detected event is never lost to a simultaneous clear
   assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & $past(set_v)) == $past(set_v)));

   // R6: a clear without a coincident event drops the flag
   assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & $past(clr_v & ~set_v)) == '0));

   // R5: any-edge in edge mode catches both directions
   assert_any_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & $past(~mode_q & any_q & inen_q & (cur ^ prev_q)))
                == $past(~mode_q & any_q & inen_q & (cur ^ prev_q))));

   // R9: no interrupt while every interrupt enable is off
   assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irqen_q == '0) |-> !irq);
endmodule

// File: rtl/wake_irq_unit.sv
module wake_irq_unit
   import wiu_pkg::*;
#(
   parameter int NUM_GROUPS  = 2,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_GROUPS*LANES-1:0] wake_pins,
   input  logic                        wr_en,
   input  logic                        rd_en,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [LANES-1:0]            wdata,
   output logic [LANES-1:0]            rdata,
   output logic                        rd_valid,
   output logic [NUM_GROUPS-1:0]       irq
);
   localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
   localparam int SEL_W = ADDR_W - REG_IDX_W;

   if (NUM_GROUPS < 1) begin : g_bad_groups
      $error("wake_irq_unit: NUM_GROUPS must be at least 1");
   end
   if (SEL_W < GRP_W) begin : g_bad_addr
      $error("wake_irq_unit: ADDR_W too small for NUM_GROUPS");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("wake_irq_unit: SYNC_STAGES must be at least 2");
   end

   logic [SEL_W-1:0]     grp_sel;
   logic [REG_IDX_W-1:0] reg_sel;
   logic [LANES-1:0]     grp_rdata [NUM_GROUPS];
   logic [LANES-1:0]     rd_mux;

   assign grp_sel = addr[ADDR_W-1:REG_IDX_W];
   assign reg_sel = addr[REG_IDX_W-1:0];

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      wiu_group #(.SYNC_STAGES(SYNC_STAGES)) u_grp (
         .clk    (clk),
         .rst_n  (rst_n),
         .pins   (wake_pins[g*LANES +: LANES]),
         .we     (wr_en && (int'(grp_sel) == g)),
         .reg_sel(reg_sel),
         .wdata  (wdata),
         .rdata  (grp_rdata[g]),
         .irq    (irq[g])
      );
   end

   always_comb begin
      rd_mux = '0;
      for (int g = 0; g < NUM_GROUPS; g++)
         if (int'(grp_sel) == g) rd_mux = grp_rdata[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata    <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rdata <= rd_mux;
      end
   end

   // R10: read data is returned exactly one cycle after the request
   assert_rd_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);
   assert_rd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);
endmodule

// File: tb/sim_wake_irq_unit.sv
module sim_wake_irq_unit;
   localparam int NG = 2;
   localparam int AW = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NG*8-1:0] pins = '0;
   logic            wr_en = 1'b0, rd_en = 1'b0;
   logic [AW-1:0]   addr = '0;
   logic [7:0]      wdata = '0;
   logic [7:0]      rdata;
   logic            rd_valid;
   logic [NG-1:0]   irq;

   int total = 0, bad = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   bit         done = 0;

   always #10 clk = ~clk;

   wake_irq_unit #(.NUM_GROUPS(NG), .ADDR_W(AW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .wake_pins(pins), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .irq(irq)
   );

   // monitor: pops expected read data as results appear
   always @(negedge clk) begin
      if (rd_valid) begin
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL unexpected read data act=%02h exp=none", rdata);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rdata !== e) begin
               bad++;
               $display("FAIL %s act=%02h exp=%02h", t, rdata, e);
            end
         end
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int g, input int r, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = AW'((g << 3) | r); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int g, input int r, input logic [7:0] e, input string t);
      @(negedge clk);
      rd_en = 1'b1; addr = AW'((g << 3) | r);
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic chk_irq(input logic [NG-1:0] e, input string t);
      total++;
      if (irq !== e) begin
         bad++;
         $display("FAIL %s irq act=%b exp=%b", t, irq, e);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      // R1: reset state
      chk_irq(2'b00, "R1 reset irq");
      for (int r = 0; r < 7; r++) rd(0, r, 8'h00, "R1 reset reg");
      rd(1, 5, 8'h00, "R1 reset pend g1");

      // R2: rising edge latency, lane 0
      wr(0, 3, 8'h01); wr(0, 4, 8'h01);
      @(negedge clk); pins[0] = 1'b1;
      wait_n(2); chk_irq(2'b00, "R2 not before third edge");
      wait_n(1); chk_irq(2'b01, "R2 at third edge");
      rd(0, 5, 8'h01, "R3 rising edge pend");

      // R6: write of zero keeps, write of one clears
      wr(0, 6, 8'h00); rd(0, 5, 8'h01, "R6 zero write no effect");
      wr(0, 6, 8'h01); rd(0, 5, 8'h00, "R6 W1C clears");
      chk_irq(2'b00, "R9 irq drops with pend");

      // R3: polarity on edges
      pins[0] = 1'b0; wait_n(5); rd(0, 5, 8'h00, "R3 falling ignored pol0");
      wr(0, 1, 8'h01);
      pins[0] = 1'b1; wait_n(5); rd(0, 5, 8'h00, "R3 rising ignored pol1");
      pins[0] = 1'b0; wait_n(5); rd(0, 5, 8'h01, "R3 falling caught pol1");
      wr(0, 6, 8'h01);

      // R5: any-edge overrides polarity
      wr(0, 2, 8'h01);
      pins[0] = 1'b1; wait_n(5); rd(0, 5, 8'h01, "R5 any-edge rising");
      wr(0, 6, 8'h01);
      pins[0] = 1'b0; wait_n(5); rd(0, 5, 8'h01, "R5 any-edge falling");
      wr(0, 6, 8'h01); rd(0, 5, 8'h00, "R5 cleared");

      // R4/R7: level high on lane 1, clear while held
      wr(0, 0, 8'h02); wr(0, 3, 8'h03);
      pins[1] = 1'b1; wait_n(5); rd(0, 5, 8'h02, "R4 level high pend");
      wr(0, 6, 8'h02); rd(0, 5, 8'h02, "R7 clear loses to held level");
      pins[1] = 1'b0; wait_n(5);
      wr(0, 6, 8'h02); rd(0, 5, 8'h00, "R4 clear after level gone");
      // R3: level low
      wr(0, 1, 8'h03); wait_n(2); rd(0, 5, 8'h02, "R3 level low pend");
      pins[1] = 1'b1; wait_n(5);
      wr(0, 6, 8'h02); rd(0, 5, 8'h00, "R3 level low released");

      // R8: input enable gating and spurious set on enable
      pins[2] = 1'b1; wait_n(5); rd(0, 5, 8'h00, "R8 disabled edge ignored");
      wr(0, 0, 8'h0A);
      pins[3] = 1'b1; wait_n(5); rd(0, 5, 8'h00, "R8 disabled level ignored");
      wr(0, 3, 8'h0B); wait_n(2); rd(0, 5, 8'h08, "R8 enable sets pend");
      pins[3] = 1'b0; wait_n(5);
      wr(0, 6, 8'h08); rd(0, 5, 8'h00, "R8 cleared");

      // R9: interrupt enable gates the output only
      wr(0, 3, 8'h1B);
      pins[4] = 1'b1; wait_n(5);
      chk_irq(2'b00, "R9 pend masked");
      rd(0, 5, 8'h10, "R9 pend present");
      wr(0, 4, 8'h11); chk_irq(2'b01, "R9 irq on enable");
      wr(0, 4, 8'h00); chk_irq(2'b00, "R9 irq off");
      rd(0, 5, 8'h10, "R9 pend kept");
      rd(0, 0, 8'h0A, "R9 mode kept");
      wr(0, 6, 8'hFF); rd(0, 5, 8'h00, "R6 clear all");

      // R11/R10: group 1 independent
      wr(1, 3, 8'h80); wr(1, 4, 8'h80);
      pins[15] = 1'b1; wait_n(5);
      chk_irq(2'b10, "R11 only group 1 irq");
      rd(1, 5, 8'h80, "R11 g1 pend");
      rd(0, 5, 8'h00, "R11 g0 untouched");
      rd(1, 6, 8'h00, "R10 clear reg reads 0");
      wr(1, 5, 8'h00); rd(1, 5, 8'h80, "R10 pend read-only");
      rd(1, 3, 8'h80, "R10 g1 inen");

      wait_n(3);
      if (exp_q.size() != 0) begin
         total++; bad++;
         $display("FAIL R10 missing reads act=%0d exp=0", exp_q.size());
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule